// File: doc/BRIEF.md
# Monochrome Host Color Expander

This block turns a one-bit-per-pixel bitmap, delivered by a host as a stream of 32-bit words, into a stream of full-color pixels for a rectangle. Software loads the rectangle's width and height together with a foreground and a background color, then pulses `start`. The block pulls host words through a valid/ready handshake and emits one colored pixel per clock for each bitmap bit while the consumer is ready. Each pixel carries its x and y position inside the rectangle. A set bit produces the foreground color and a clear bit produces the background color, and the chosen color simply replaces whatever is at the destination.

Bitmap rows are byte-aligned in the host stream, so the unused low bits of the last byte of each row are skipped. Inside a host word the byte in bits 7:0 is used first, then bits 15:8, then 23:16, then 31:24. Inside each byte the most significant bit is used first. The block knows how many words the rectangle needs. It takes no word after the one that holds the last pixel, and it raises `done` once that pixel has been delivered. `done` stays high until the next accepted `start`.

Top module: `mono_expand`

## Requirements
- R1: After a synchronous active-low reset, `pix_valid`, `word_ready`, `busy` and `done` are all 0.
- R2: Within a host word, the byte in bits 7:0 is expanded first, followed by bits 15:8, then 23:16, then 31:24.
- R3: Within each byte, pixels are taken from bit 7 down to bit 0, with bit 7 being the leftmost pixel.
- R4: A bitmap bit of 1 yields the latched foreground color on `pix_color`, and a bit of 0 yields the latched background color.
- R5: Pixels are delivered with `pix_x` counting up from 0 to width-1 within a row, and rows are delivered with `pix_y` counting up from 0 to height-1.
- R6: Every row starts on a fresh byte and occupies ceil(width/8) bytes. The bits in the last byte of a row that lie after the row's final pixel produce no pixel.
- R7: A rectangle consumes exactly ceil(ceil(width/8)*height/4) host words. Any padding bytes in the final word produce no pixel, and `word_ready` stays 0 after that word until the next start.
- R8: The cycle after the last pixel handshake, `done` is 1 and `busy` is 0. `done` then holds until the next accepted start, and `busy` and `done` are never 1 together.
- R9: A `start` pulse while `busy` is 1 is ignored. The current rectangle continues with its latched size and colors, whatever values appear on `cfg_width`, `cfg_height`, `fg_color` and `bg_color`.
- R10: A start with width 0 or height 0 raises `done` on the next cycle, and no host word is ever accepted for that rectangle.
- R11: While `pix_valid` is 1 and `pix_ready` is 0, the presented pixel (color, x, y) holds unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a rectangle; accepted only when not busy |
| cfg_width | input | DIM_W | Rectangle width in pixels, latched at start |
| cfg_height | input | DIM_W | Rectangle height in rows, latched at start |
| fg_color | input | COLOR_W | Color used for 1 bits, latched at start |
| bg_color | input | COLOR_W | Color used for 0 bits, latched at start |
| word_valid | input | 1 | Host word offered |
| word_data | input | WORD_W | Host bitmap word, first byte in bits 7:0 |
| word_ready | output | 1 | Block takes the offered word this cycle |
| pix_valid | output | 1 | A pixel is presented |
| pix_ready | input | 1 | Consumer takes the presented pixel |
| pix_color | output | COLOR_W | Expanded pixel color |
| pix_x | output | DIM_W | Pixel column within the rectangle |
| pix_y | output | DIM_W | Pixel row within the rectangle |
| busy | output | 1 | A rectangle is being expanded |
| done | output | 1 | The last rectangle has completed |

## Verification
Two events can fall on the same pixel handshake: the end of a row and the exhaustion of the current host word. The first happens when a row's last pixel lies in the byte at bits 31:24. The second happens when the rectangle's final pixel sits in a word that still has padding bytes. Widths of 32 and 40, and single-byte rectangles, are chosen so that these coincide. The result is judged at the ports in three ways. The next row's first pixel must come from bit 7 of the new word's first byte. The count of accepted words must match the computed total exactly, while the bench keeps offering surplus words. `done` must rise on the cycle after the final handshake, with random stalls on `pix_ready` to shift where these boundaries land in time.

// File: rtl/mono_expand_pkg.sv
// Shared types for the monochrome color expander.
package mono_expand_pkg;

    // Control state of the expander.
    typedef enum logic [1:0] {
        MX_IDLE = 2'd0,
        MX_RUN  = 2'd1,
        MX_DONE = 2'd2
    } mx_state_t;

endpackage

// File: rtl/mono_expand_cursor.sv
// Pixel position tracker for the expander.
// Holds the rectangle size latched at load and walks x/y in raster order,
// one step per delivered pixel. Assumes load and step are never together
// and that step only occurs for non-zero dimensions.
module mono_expand_cursor #(
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [DIM_W-1:0] width_in,
    input  logic [DIM_W-1:0] height_in,
    output logic [DIM_W-1:0] x,
    output logic [DIM_W-1:0] y,
    output logic             row_end,
    output logic             last
);

    logic [DIM_W-1:0] w_r;
    logic [DIM_W-1:0] h_r;

    assign row_end = (x == w_r - DIM_W'(1));
    assign last    = row_end && (y == h_r - DIM_W'(1));

    // Latch size on load; advance column, wrapping to the next row at row end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_r <= '0;
            h_r <= '0;
            x   <= '0;
            y   <= '0;
        end else if (load) begin
            w_r <= width_in;
            h_r <= height_in;
            x   <= '0;
            y   <= '0;
        end else if (step) begin
            if (row_end) begin
                x <= '0;
                y <= y + DIM_W'(1);
            end else begin
                x <= x + DIM_W'(1);
            end
        end
    end

    // A delivered pixel always lies inside the latched rectangle.
    assert_coord_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (x < w_r) && (y < h_r));

endmodule

// File: rtl/mono_expand_wordbuf.sv
// Single-word holding buffer with a byte/bit pointer.
// Takes a host word when empty and enabled, presents the bit selected by
// the pointer (byte 0 first, MSB first), and frees itself when its last
// byte is used up, when the row ends in its last byte, or when told the
// rectangle is finished. Assumes WORD_W is a power-of-two multiple of 8.
module mono_expand_wordbuf #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              step,
    input  logic              skip,
    input  logic              drop,
    output logic              have,
    output logic              cur_bit
);

    localparam int BYTES = WORD_W / 8;
    localparam int BI_W  = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic [WORD_W-1:0] data_r;
    logic [BI_W-1:0]   byte_idx;
    logic [2:0]        bit_idx;
    logic              byte_end;
    logic              last_byte;

    assign in_ready  = enable && !have;
    assign cur_bit   = data_r[{byte_idx, bit_idx}];
    assign byte_end  = skip || (bit_idx == 3'd0);
    assign last_byte = (byte_idx == BI_W'(BYTES - 1));

    // Load a word when empty; move the pointer per pixel and release the word when spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_r   <= '0;
            byte_idx <= '0;
            bit_idx  <= 3'd7;
            have     <= 1'b0;
        end else if (clear) begin
            have     <= 1'b0;
        end else if (in_valid && in_ready) begin
            data_r   <= in_data;
            byte_idx <= '0;
            bit_idx  <= 3'd7;
            have     <= 1'b1;
        end else if (step) begin
            if (drop) begin
                have <= 1'b0;
            end else if (byte_end) begin
                bit_idx <= 3'd7;
                if (last_byte) begin
                    have     <= 1'b0;
                    byte_idx <= '0;
                end else begin
                    byte_idx <= byte_idx + BI_W'(1);
                end
            end else begin
                bit_idx <= bit_idx - 3'd1;
            end
        end
    end

    // A pixel is only consumed from a held word.
    assert_step_needs_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> have);

    // A fresh word always begins at its lowest byte, most significant bit.
    assert_fresh_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !clear) |=> have && cur_bit == data_r[8*0 + 7]);

endmodule

// File: rtl/mono_expand.sv
// Monochrome-to-color expander top.
// Accepts a rectangle size and two colors at start, pulls 1-bpp bitmap
// words from the host and delivers one colored pixel per ready cycle with
// its x/y position, then signals done. Assumes the host supplies words in
// stream order; start is only honoured while not busy.
module mono_expand
    import mono_expand_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int COLOR_W = 32,
    parameter int DIM_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DIM_W-1:0]   cfg_width,
    input  logic [DIM_W-1:0]   cfg_height,
    input  logic [COLOR_W-1:0] fg_color,
    input  logic [COLOR_W-1:0] bg_color,
    input  logic               word_valid,
    input  logic [WORD_W-1:0]  word_data,
    output logic               word_ready,
    output logic               pix_valid,
    input  logic               pix_ready,
    output logic [COLOR_W-1:0] pix_color,
    output logic [DIM_W-1:0]   pix_x,
    output logic [DIM_W-1:0]   pix_y,
    output logic               busy,
    output logic               done
);

    mx_state_t          state;
    logic [COLOR_W-1:0] fg_r;
    logic [COLOR_W-1:0] bg_r;
    logic               take_start;
    logic               zero_dim;
    logic               fire;
    logic               row_end;
    logic               last;
    logic               have;
    logic               cur_bit;
    logic               running;

    assign running    = (state == MX_RUN);
    assign take_start = start && !running;
    assign zero_dim   = (cfg_width == '0) || (cfg_height == '0);
    assign pix_valid  = running && have;
    assign fire       = pix_valid && pix_ready;
    assign pix_color  = cur_bit ? fg_r : bg_r;
    assign busy       = running;
    assign done       = (state == MX_DONE);

    mono_expand_cursor #(.DIM_W(DIM_W)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_start),
        .step      (fire),
        .width_in  (cfg_width),
        .height_in (cfg_height),
        .x         (pix_x),
        .y         (pix_y),
        .row_end   (row_end),
        .last      (last)
    );

    mono_expand_wordbuf #(.WORD_W(WORD_W)) u_wordbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (take_start),
        .enable   (running),
        .in_valid (word_valid),
        .in_data  (word_data),
        .in_ready (word_ready),
        .step     (fire),
        .skip     (row_end),
        .drop     (last),
        .have     (have),
        .cur_bit  (cur_bit)
    );

    // Sequence idle -> run -> done, skipping straight to done for an empty rectangle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MX_IDLE;
        end else if (take_start) begin
            state <= zero_dim ? MX_DONE : MX_RUN;
        end else if (fire && last) begin
            state <= MX_DONE;
        end
    end

    // Capture the two colors when a rectangle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg_r <= '0;
            bg_r <= '0;
        end else if (take_start) begin
            fg_r <= fg_color;
            bg_r <= bg_color;
        end
    end

    // Done follows the final pixel handshake.
    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last) |=> done && !busy);

    // Busy and done are mutually exclusive.
    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));

    // Once finished, no further words or pixels move.
    assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !word_ready && !pix_valid);

    // A stalled pixel is held steady.
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> pix_valid && $stable(pix_color)
                                      && $stable(pix_x) && $stable(pix_y));

endmodule

// File: tb/sim_mono_expand.sv
module sim_mono_expand;

    localparam int WORD_W  = 32;
    localparam int COLOR_W = 32;
    localparam int DIM_W   = 12;

    typedef struct packed {
        int          w;
        int          h;
        logic [31:0] fg;
        logic [31:0] bg;
        int          seed;
        bit          stall;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{w: 8,  h: 1, fg: 32'hFFFF_FFFF, bg: 32'h0000_0000, seed: 17, stall: 1'b0},
        '{w: 3,  h: 4, fg: 32'h1234_5678, bg: 32'h9ABC_DEF0, seed: 29, stall: 1'b0},
        '{w: 32, h: 2, fg: 32'hAAAA_0001, bg: 32'h5555_0002, seed: 43, stall: 1'b0},
        '{w: 13, h: 5, fg: 32'hC0DE_C0DE, bg: 32'h0BAD_F00D, seed: 71, stall: 1'b1},
        '{w: 1,  h: 1, fg: 32'h0000_00FF, bg: 32'h0000_FF00, seed: 5,  stall: 1'b0},
        '{w: 40, h: 3, fg: 32'h0F0F_0F0F, bg: 32'hF0F0_F0F0, seed: 97, stall: 1'b1},
        '{w: 9,  h: 7, fg: 32'h1111_2222, bg: 32'h3333_4444, seed: 113, stall: 1'b1}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [DIM_W-1:0]   cfg_width = '0;
    logic [DIM_W-1:0]   cfg_height = '0;
    logic [COLOR_W-1:0] fg_color = '0;
    logic [COLOR_W-1:0] bg_color = '0;
    logic               word_valid = 1'b0;
    logic [WORD_W-1:0]  word_data = '0;
    logic               word_ready;
    logic               pix_valid;
    logic               pix_ready = 1'b0;
    logic [COLOR_W-1:0] pix_color;
    logic [DIM_W-1:0]   pix_x;
    logic [DIM_W-1:0]   pix_y;
    logic               busy;
    logic               done;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    mono_expand #(.WORD_W(WORD_W), .COLOR_W(COLOR_W), .DIM_W(DIM_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .fg_color(fg_color), .bg_color(bg_color),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_color(pix_color),
        .pix_x(pix_x), .pix_y(pix_y), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bm_byte(input int seed, input int i);
        return 8'((seed * (i + 3)) ^ (i * 37) ^ (seed >> 1));
    endfunction

    // Expands one rectangle and checks every pixel, the word count and done.
    task automatic run_rect(input int w, input int h, input logic [31:0] fg,
                            input logic [31:0] bg, input int seed,
                            input bit stall, input bit poke);
        int rb, nbytes, nwords, widx, ex, ey, npix, cyc, bi;
        bit held;
        logic [COLOR_W-1:0] hc;
        logic [DIM_W-1:0] hx, hy;
        logic [7:0] b;
        logic exp_bit;
        logic [31:0] exp_col;
        rb = (w + 7) / 8;
        nbytes = rb * h;
        nwords = (nbytes + 3) / 4;
        widx = 0; ex = 0; ey = 0; npix = 0; cyc = 0; held = 1'b0;
        hc = '0; hx = '0; hy = '0;
        @(negedge clk);
        cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
        fg_color = fg; bg_color = bg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 4000) begin
            word_valid = 1'b1;
            for (int k = 0; k < 4; k++) begin
                bi = 4 * widx + k;
                word_data[8*k +: 8] = (bi < nbytes) ? bm_byte(seed, bi) : 8'hEE;
            end
            pix_ready = stall ? (cyc % 3 != 1) : 1'b1;
            start = poke && (cyc == 4);
            if (poke && cyc >= 4) begin
                cfg_width = DIM_W'(5); cfg_height = DIM_W'(1);
                fg_color = ~fg; bg_color = ~bg;
            end
            #1;
            if (held) begin
                // R11: stalled pixel must be unchanged
                chk(pix_valid && pix_color == hc && pix_x == hx && pix_y == hy,
                    "R11 stall hold", {pix_x, pix_y}, {hx, hy});
                held = 1'b0;
            end
            if (pix_valid && !pix_ready) begin
                held = 1'b1; hc = pix_color; hx = pix_x; hy = pix_y;
            end
            if (word_valid && word_ready) begin
                chk(widx < nwords, "R7 surplus word taken", widx, nwords);
                widx++;
            end
            if (pix_valid && pix_ready) begin
                b = bm_byte(seed, ey * rb + ex / 8);
                exp_bit = b[7 - (ex % 8)];
                exp_col = exp_bit ? fg : bg;
                // R5: raster position
                chk(int'(pix_x) == ex && int'(pix_y) == ey, "R5 position",
                    {pix_y, pix_x}, {DIM_W'(ey), DIM_W'(ex)});
                // R2 R3 R4 R6 R9: byte order, bit order, color select, row padding, start ignored
                chk(pix_color == exp_col, "R2 R3 R4 R6 R9 color", pix_color, exp_col);
                npix++;
                if (ex == w - 1) begin ex = 0; ey++; end else ex++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(npix == w * h, "R6 pixel count", npix, w * h);
        chk(widx == nwords, "R7 word count", widx, nwords);
        chk(done && !busy, "R8 done after last", {busy, done}, 2'b01);
        for (int t = 0; t < 3; t++) begin
            word_valid = 1'b1;
            #1;
            chk(!word_ready && !pix_valid, "R7 no word after end", word_ready, 0);
            chk(done, "R8 done holds", done, 1);
            @(negedge clk);
        end
        word_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(!pix_valid && !word_ready && !busy && !done, "R1 reset outputs",
            {pix_valid, word_ready, busy, done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!busy && !done && !word_ready, "R1 idle after reset",
            {busy, done, word_ready}, 0);

        for (int i = 0; i < NV; i++)
            run_rect(VECS[i].w, VECS[i].h, VECS[i].fg, VECS[i].bg,
                     VECS[i].seed, VECS[i].stall, 1'b0);

        // R9: start pulse and changed configuration during a run are ignored
        run_rect(13, 3, 32'hDEAD_BEEF, 32'h0102_0304, 61, 1'b1, 1'b1);

        // R10: zero width finishes immediately without taking words
        @(negedge clk);
        cfg_width = '0; cfg_height = DIM_W'(4); start = 1'b1;
        @(negedge clk);
        start = 1'b0; word_valid = 1'b1;
        #1;
        chk(done && !busy, "R10 zero width done", {busy, done}, 2'b01);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            #1;
            chk(!word_ready, "R10 no word for empty", word_ready, 0);
        end
        // R10: zero height
        @(negedge clk);
        cfg_width = DIM_W'(7); cfg_height = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(done && !word_ready && !pix_valid, "R10 zero height done",
            {done, word_ready, pix_valid}, 3'b100);
        word_valid = 1'b0;

        // R1: reset clears done
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(!done && !busy && !pix_valid, "R1 reset clears done", {done, busy}, 0);
        rst_n = 1'b1;

        // Rectangle after reset still works
        run_rect(16, 2, 32'h7777_7777, 32'h8888_8888, 83, 1'b0, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule